// File: doc/BRIEF.md
# Register Redirection Tag Lookup

This block widens a 5-bit architectural register operand into a 7-bit physical register index by looking it up in a small key-value table of sixteen 16-bit tag words. Each tag word names the operand key it captures, the register file it belongs to (integer or floating point), the physical index to redirect to, whether that register is a vector, and an element-width override code. Unmodified instructions can therefore reach a register file four times larger than their operand field alone would allow.

The tag words arrive as one flat vector, with word n in bits [16n+15:16n]. The match and the selection among entries are combinational. The result is captured in a single output register stage whenever the enable input is high, so a result is visible one clock after the operand is presented. When no tag matches, the operand passes through unchanged as a scalar with the default width code.

Tag word layout: bit 15 vector flag, bits 14..8 target index, bit 7 register-file selector (1 = integer, 0 = floating point), bits 6..5 width override, bits 4..0 key. Width codes: 2'b00 keeps the instruction's normal width, 2'b01 selects 32 bits, 2'b10 selects 16 bits and 2'b11 selects 8 bits.

Top module: `rr_lookup`

## Requirements
- R1: While rst_n is low, and after it until the first enabled clock edge, hit_q, idx_q, vec_q and ew_q are all zero.
- R2: A tag word matches when it is not all-zero, its bits 4..0 equal op_key and its bit 7 equals op_is_int. On a match the registered result is hit_q=1, idx_q=bits 14..8, vec_q=bit 15 and ew_q=bits 6..5 of that word (the width code is passed through unaltered, all four codes 00, 01, 10, 11).
- R3: A tag word whose bit 7 differs from op_is_int never matches, even when its key equals op_key.
- R4: An all-zero tag word never matches, including for a floating-point operand with key 0.
- R5: When several tag words match, the one at the highest word position supplies the result.
- R6: When no tag word matches, hit_q=0, idx_q={2'b00, op_key}, vec_q=0 and ew_q=2'b00.
- R7: With lk_en low at a rising clock edge, all outputs keep their previous values whatever the other inputs do.
- R8: With lk_en high at a rising clock edge, the outputs after that edge reflect the op_key, op_is_int and tag_words present just before it (one cycle latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_en | input | 1 | Capture the lookup result at this edge |
| op_key | input | 5 | Architectural register operand |
| op_is_int | input | 1 | 1 = integer operand, 0 = floating-point operand |
| tag_words | input | N_ENTRIES*16 | Flat vector of tag words, word n in bits [16n+15:16n] |
| hit_q | output | 1 | A tag word matched |
| idx_q | output | 7 | Redirected (or zero-extended) register index |
| vec_q | output | 1 | Register is treated as a vector |
| ew_q | output | 2 | Element-width override code |

## Verification
A wrong match decision shows up at the ports on the clock after the enabled edge: either hit_q rises for an operand of the wrong register file or for an unused all-zero word, or a miss delivers a nonzero upper index, vector flag or width code. A wrong priority among duplicate keys shows as the target index of a lower word in that same cycle. A faulty enable path shows as outputs changing on the first edge with lk_en low.

// File: rtl/rr_pkg.sv
package rr_pkg;

    localparam int KEY_W   = 5;
    localparam int IDX_W   = 7;
    localparam int TAG_W   = 16;
    localparam int N_TAGS  = 16;

    // Element-width override code
    typedef enum logic [1:0] {
        EW_DEFAULT = 2'b00,
        EW_32      = 2'b01,
        EW_16      = 2'b10,
        EW_8       = 2'b11
    } ew_e;

    // Tag word, MSB first: vector flag, target, file select, width, key
    typedef struct packed {
        logic             vec;
        logic [IDX_W-1:0] tgt;
        logic             is_int;
        ew_e              ew;
        logic [KEY_W-1:0] key;
    } tag_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             vec;
        ew_e              ew;
    } res_t;

endpackage

// File: rtl/rr_tag_cmp.sv
module rr_tag_cmp
    import rr_pkg::*;
(
    input  tag_t             tag,
    input  logic [KEY_W-1:0] key,
    input  logic             is_int,
    output logic             match
);
    logic used;

    always_comb begin
        used  = (tag != '0);
        match = used && (tag.key == key) && (tag.is_int == is_int);
    end
endmodule

// File: rtl/rr_prio_pick.sv
module rr_prio_pick
    import rr_pkg::*;
#(
    parameter int N = N_TAGS
) (
    input  tag_t [N-1:0]     tags,
    input  logic [N-1:0]     match,
    input  logic [KEY_W-1:0] key,
    output res_t             res
);
    localparam int PAD_W = IDX_W - KEY_W;

    always_comb begin
        // miss default: operand widened, scalar, normal width
        res.hit = 1'b0;
        res.idx = {{PAD_W{1'b0}}, key};
        res.vec = 1'b0;
        res.ew  = EW_DEFAULT;
        // ascending scan, later words overwrite earlier ones
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                res.hit = 1'b1;
                res.idx = tags[i].tgt;
                res.vec = tags[i].vec;
                res.ew  = tags[i].ew;
            end
        end
    end
endmodule

// File: rtl/rr_out_reg.sv
module rr_out_reg
    import rr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  res_t d,
    output res_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/rr_lookup.sv
module rr_lookup
    import rr_pkg::*;
#(
    parameter int N_ENTRIES = N_TAGS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_en,
    input  logic [KEY_W-1:0]           op_key,
    input  logic                       op_is_int,
    input  logic [N_ENTRIES*TAG_W-1:0] tag_words,
    output logic                       hit_q,
    output logic [IDX_W-1:0]           idx_q,
    output logic                       vec_q,
    output logic [1:0]                 ew_q
);
    tag_t [N_ENTRIES-1:0] tags;
    logic [N_ENTRIES-1:0] match;
    res_t                 res_c;
    res_t                 res_q;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_tag
        assign tags[g] = tag_t'(tag_words[g*TAG_W +: TAG_W]);

        rr_tag_cmp u_cmp (
            .tag    (tags[g]),
            .key    (op_key),
            .is_int (op_is_int),
            .match  (match[g])
        );
    end

    rr_prio_pick #(.N(N_ENTRIES)) u_pick (
        .tags  (tags),
        .match (match),
        .key   (op_key),
        .res   (res_c)
    );

    rr_out_reg u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (lk_en),
        .d     (res_c),
        .q     (res_q)
    );

    always_comb begin
        hit_q = res_q.hit;
        idx_q = res_q.idx;
        vec_q = res_q.vec;
        ew_q  = res_q.ew;
    end
endmodule

// File: rtl/rr_lookup_chk.sv
module rr_lookup_chk
    import rr_pkg::*;
#(
    parameter int N_ENTRIES = N_TAGS
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       lk_en,
    input logic [KEY_W-1:0]           op_key,
    input logic                       op_is_int,
    input logic [N_ENTRIES*TAG_W-1:0] tag_words,
    input logic                       hit_q,
    input logic [IDX_W-1:0]           idx_q,
    input logic                       vec_q,
    input logic [1:0]                 ew_q
);
    // no word is of the operand's register file
    logic none_same_file;
    always_comb begin
        none_same_file = 1'b1;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (tag_words[i*TAG_W + 7] == op_is_int) none_same_file = 1'b0;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!hit_q && idx_q == '0 && !vec_q && ew_q == 2'b00));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |=> ($stable(hit_q) && $stable(idx_q) && $stable(vec_q) && $stable(ew_q)));

    a_r6_miss_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_q |-> (idx_q[IDX_W-1:KEY_W] == '0 && !vec_q && ew_q == 2'b00));

    a_r6_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |=> (hit_q || idx_q[KEY_W-1:0] == $past(op_key)));

    a_r4_zero_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && tag_words == '0) |=> !hit_q);

    a_r3_file_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && none_same_file) |=> !hit_q);
endmodule

bind rr_lookup rr_lookup_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_en     (lk_en),
    .op_key    (op_key),
    .op_is_int (op_is_int),
    .tag_words (tag_words),
    .hit_q     (hit_q),
    .idx_q     (idx_q),
    .vec_q     (vec_q),
    .ew_q      (ew_q)
);

// File: tb/rr_lookup_tb.sv
module rr_lookup_tb;
    localparam int N  = 16;
    localparam int TW = N * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_en = 1'b0;
    logic [4:0]    op_key = '0;
    logic          op_is_int = 1'b0;
    logic [TW-1:0] tag_words = '0;
    logic          hit_q;
    logic [6:0]    idx_q;
    logic          vec_q;
    logic [1:0]    ew_q;

    int n_chk = 0;
    int n_bad = 0;
    logic [10:0] last_exp = '0;

    always #2 clk = ~clk;

    rr_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .op_key(op_key),
        .op_is_int(op_is_int), .tag_words(tag_words),
        .hit_q(hit_q), .idx_q(idx_q), .vec_q(vec_q), .ew_q(ew_q)
    );

    function automatic logic [15:0] mk(input logic v, input logic [6:0] t,
                                       input logic fi, input logic [1:0] w,
                                       input logic [4:0] k);
        return {v, t, fi, w, k};
    endfunction

    // {hit, idx, vec, ew}, from R2..R6
    function automatic logic [10:0] model(input logic [TW-1:0] w,
                                          input logic [4:0] k, input logic fi);
        logic [10:0] r = {1'b0, 2'b00, k, 1'b0, 2'b00};
        for (int i = 0; i < N; i++) begin
            logic [15:0] e = w[i*16 +: 16];
            if (e != 16'h0 && e[4:0] == k && e[7] == fi)
                r = {1'b1, e[14:8], e[15], e[6:5]};
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [10:0] exp);
        logic [10:0] act = {hit_q, idx_q, vec_q, ew_q};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [TW-1:0] w,
                        input logic [4:0] k, input logic fi, input logic en);
        @(negedge clk);
        tag_words = w; op_key = k; op_is_int = fi; lk_en = en;
        if (en) last_exp = model(w, k, fi);
        @(negedge clk);
        check(req, last_exp);
        lk_en = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [TW-1:0] w;
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        check("R1", 11'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 11'h0);

        // R2: single integer hit, each width code
        for (int c = 0; c < 4; c++) begin
            w = '0;
            w[3*16 +: 16] = mk(1'b1, 7'd70 + 7'(c), 1'b1, 2'(c), 5'd9);
            step("R2", w, 5'd9, 1'b1, 1'b1);
        end
        // R2 floating-point hit
        w = '0;
        w[0 +: 16] = mk(1'b0, 7'd100, 1'b0, 2'b10, 5'd31);
        step("R2", w, 5'd31, 1'b0, 1'b1);
        // R3: same key, other file
        step("R3", w, 5'd31, 1'b1, 1'b1);
        // R4: all-zero words, fp operand 0
        step("R4", '0, 5'd0, 1'b0, 1'b1);
        // R5: duplicates, highest wins
        w = '0;
        w[2*16 +: 16]  = mk(1'b0, 7'd10, 1'b1, 2'b01, 5'd4);
        w[7*16 +: 16]  = mk(1'b1, 7'd77, 1'b1, 2'b11, 5'd4);
        w[12*16 +: 16] = mk(1'b0, 7'd120, 1'b1, 2'b10, 5'd4);
        step("R5", w, 5'd4, 1'b1, 1'b1);
        // R6: miss
        step("R6", w, 5'd22, 1'b1, 1'b1);
        // R7: enable low, inputs change, outputs hold
        step("R8", w, 5'd4, 1'b1, 1'b1);
        step("R7", '0, 5'd17, 1'b0, 1'b0);
        step("R7", w, 5'd2, 1'b1, 1'b0);

        // random, keys in a small range to force matches
        for (int v = 0; v < 400; v++) begin
            logic [4:0] k = 5'($urandom % 4);
            logic fi = 1'($urandom);
            logic en = ($urandom % 5) != 0;
            for (int i = 0; i < N; i++) begin
                if ($urandom % 4 == 0) w[i*16 +: 16] = '0;
                else w[i*16 +: 16] = mk(1'($urandom), 7'($urandom), 1'($urandom),
                                        2'($urandom), 5'($urandom % 4));
            end
            step(en ? "R8" : "R7", w, k, fi, en);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule